// File: doc/BRIEF.md
# Retirement trace packet serializer

The block takes the retirement record of one instruction, captures it whole on a retire strobe, and sends it out as a stream of 64-bit beats with a valid/ready handshake and a last marker. The record holds instruction metadata (sequence number, instruction word, trap, halt, interrupt, privilege and register-width bytes), the program counter before and after the instruction, integer register traffic and a memory access. Two presence flags state whether the integer part and the memory part carry meaning for this instruction.

In the default, variable-length format the packet is a 512-bit header, then a 320-bit integer extension if the integer flag is set, then a 704-bit memory extension if the memory flag is set. The header carries an ASCII magic word, the byte count of the whole packet and one availability bit per extension, and each extension opens with its own magic word. When the mode input is high at capture time, the record is sent instead in a fixed 704-bit legacy layout. A capability request makes the block send a legacy-sized packet that advertises support for the variable-length format. Only one packet is in flight at a time; the retire input is held off until the last beat has been taken.

The controller has five states. `TX_IDLE` waits. A capability request moves it to `TX_LEGACY`. Otherwise a retire strobe moves it to `TX_LEGACY` when the mode input is high and to `TX_HEAD` when it is low. `TX_HEAD` goes on to `TX_INTX`, `TX_MEMX` or `TX_IDLE`, depending on the captured flags. `TX_INTX` goes on to `TX_MEMX` or `TX_IDLE`. `TX_MEMX` and `TX_LEGACY` return to `TX_IDLE` after their eleventh beat.

Top module: `rtrace_serializer`

## Requirements
- R1: After reset `out_valid` is 0 and `ret_ready` is 1. `ret_ready` is 1 only while no packet is in flight and `cap_req` is low, and a record is captured on a cycle with `ret_valid` and `ret_ready` both high.
- R2: Each 64-bit word of a packet is sent least-significant word first. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R3: Header beats, in order:
  - beat 0 is 0x32762d6563617274;
  - beat 1 is the byte count;
  - beat 2 is the order number;
  - beat 3 is the instruction word;
  - beat 4 is {16'h0, 8'h01, ixl, mode, intr, halt, trap} (the 8'h01 is the valid byte);
  - beat 5 is the PC before the instruction;
  - beat 6 is the PC after the instruction;
  - beat 7 has bit 0 set to the integer flag and bit 1 set to the memory flag, with all other bits zero.
- R4: Integer extension beats, in order:
  - beat 0 is 0x617461642d746e69;
  - beats 1, 2 and 3 are the destination write value, source-1 value and source-2 value;
  - beat 4 is {40'h0, rs2_addr, rs1_addr, rd_addr}.
- R5: A register value whose register address is zero is sent as zero, in both formats.
- R6: Memory extension beats, in order:
  - beat 0 is 0x617461642d6d656d;
  - beats 1 to 4 are the 256-bit read data, low word first;
  - beats 5 to 8 are the 256-bit write data, low word first;
  - beat 9 is {write mask, read mask};
  - beat 10 is the address.
- R7: A variable-length packet is the header, then the integer extension, then the memory extension, with each extension present only if its flag was set at capture. The beat count equals the byte count divided by 8 (8, 13, 19 or 24 beats). `out_last` is high only on the final beat, and `out_valid` falls after that beat is taken.
- R8: With `legacy_mode` high at capture, the packet is 11 beats:
  - beats 0 to 9 are the order number, PC before, PC after, instruction word, source-1 value, source-2 value, destination write value, memory address, read data and write data;
  - beat 10 is {intr, halt, trap, rd_addr, rs2_addr, rs1_addr, write mask, read mask}.

  `legacy_mode` and the record inputs are not looked at again after capture.
- R9: In the legacy layout the masks are cut to their low 8 bits and the memory data to its low 64 bits. The fields of an extension whose flag is low are sent as zero.
- R10: A capability packet is 11 beats, all zero except beat 10, which is 64'h0003_0000_0000_0000 (halt byte 0x03).
- R11: `cap_req` wins over `ret_valid` when both are high in an idle cycle. A `cap_req` raised while a packet is in flight has no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| legacy_mode | input | 1 | Selects the fixed legacy layout for the record being captured |
| cap_req | input | 1 | Request to send the capability packet |
| ret_valid | input | 1 | Retirement record present |
| ret_ready | output | 1 | Block can capture a record this cycle |
| rt_order | input | 64 | Instruction sequence number |
| rt_insn | input | 64 | Instruction word, zero-extended |
| rt_trap | input | 8 | Trap byte |
| rt_halt | input | 8 | Halt byte |
| rt_intr | input | 8 | Interrupt byte (first instruction of a handler) |
| rt_mode | input | 8 | Privilege level: 0 user, 1 supervisor, 3 machine |
| rt_ixl | input | 8 | Register width: 1 is 32-bit, 2 is 64-bit |
| rt_pc_rdata | input | 64 | PC of the instruction |
| rt_pc_wdata | input | 64 | PC of the next instruction |
| rt_int_present | input | 1 | Integer register data is meaningful |
| rt_rd_addr | input | 8 | Destination register address |
| rt_rs1_addr | input | 8 | Source-1 register address |
| rt_rs2_addr | input | 8 | Source-2 register address |
| rt_rd_wdata | input | 64 | Value written to the destination register |
| rt_rs1_rdata | input | 64 | Value read from source 1 |
| rt_rs2_rdata | input | 64 | Value read from source 2 |
| rt_mem_present | input | 1 | Memory access data is meaningful |
| rt_mem_addr | input | 64 | Accessed byte address |
| rt_mem_rdata | input | 256 | Data read |
| rt_mem_wdata | input | 256 | Data written |
| rt_mem_rmask | input | 32 | Valid bytes of the read data |
| rt_mem_wmask | input | 32 | Valid bytes of the write data |
| out_valid | output | 1 | Beat on `out_data` is valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 64 | Packet beat |
| out_last | output | 1 | Final beat of the packet |

## Verification
The packet layout is fixed, so the bench builds the block with the package constants as they stand: 64-bit beats, 256-bit memory lanes and 32-bit masks. With these values every combination of the two presence flags can be reached in both formats, which covers all four header byte counts and both points where the state machine skips an extension. The sources of zero addresses the register-value zeroing rule, and a stall pattern holds the stream between beats. The bench also changes the mode input and the record inputs while a packet is being sent, and raises a capability request during a packet, to show that neither reaches a packet already captured.

// File: rtl/rtrace_pkg.sv
package rtrace_pkg;
    localparam int BEAT_W     = 64;
    localparam int WORD_W     = 64;
    localparam int BYTE_W     = 8;
    localparam int LANE_W     = 256;
    localparam int MASK_W     = 32;
    localparam int HDR_W      = 512;
    localparam int INTX_W     = 320;
    localparam int MEMX_W     = 704;
    localparam int LEG_W      = 704;
    localparam int HDR_BEATS  = HDR_W / BEAT_W;
    localparam int INT_BEATS  = INTX_W / BEAT_W;
    localparam int MEM_BEATS  = MEMX_W / BEAT_W;
    localparam int LEG_BEATS  = LEG_W / BEAT_W;
    localparam int MAX_SEG    = (MEM_BEATS > LEG_BEATS) ? MEM_BEATS : LEG_BEATS;
    localparam int IDX_W      = $clog2(MAX_SEG);

    localparam logic [WORD_W-1:0] HDR_MAGIC = 64'h3276_2d65_6361_7274;
    localparam logic [WORD_W-1:0] INT_MAGIC = 64'h6174_6164_2d74_6e69;
    localparam logic [WORD_W-1:0] MEM_MAGIC = 64'h6174_6164_2d6d_656d;
    localparam logic [BYTE_W-1:0] META_VALID_BYTE = 8'h01;
    localparam logic [BYTE_W-1:0] CAP_HALT_BYTE   = 8'h03;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_HEAD,
        TX_INTX,
        TX_MEMX,
        TX_LEGACY
    } tx_state_e;
endpackage

// File: rtl/rtrace_beat_sel.sv
module rtrace_beat_sel #(
    parameter int SRC_W  = 512,
    parameter int BEAT_W = 64,
    parameter int IDX_W  = 4
) (
    input  logic [SRC_W-1:0]  src,
    input  logic [IDX_W-1:0]  idx,
    output logic [BEAT_W-1:0] beat
);
    localparam int NWORDS = SRC_W / BEAT_W;

    logic [BEAT_W-1:0] words [NWORDS];

    generate
        for (genvar g = 0; g < NWORDS; g++) begin : g_split
            assign words[g] = src[g*BEAT_W +: BEAT_W];
        end
    endgenerate

    always_comb begin
        beat = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (idx == IDX_W'(i)) beat = words[i];
        end
    end
endmodule

// File: rtl/rtrace_pack_v2.sv
module rtrace_pack_v2
    import rtrace_pkg::*;
(
    input  logic [WORD_W-1:0] order,
    input  logic [WORD_W-1:0] insn,
    input  logic [BYTE_W-1:0] trap,
    input  logic [BYTE_W-1:0] halt,
    input  logic [BYTE_W-1:0] intr,
    input  logic [BYTE_W-1:0] mode,
    input  logic [BYTE_W-1:0] ixl,
    input  logic [WORD_W-1:0] pc_rdata,
    input  logic [WORD_W-1:0] pc_wdata,
    input  logic              int_on,
    input  logic              mem_on,
    input  logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rs1_addr,
    input  logic [BYTE_W-1:0] rs2_addr,
    input  logic [WORD_W-1:0] rd_wdata,
    input  logic [WORD_W-1:0] rs1_rdata,
    input  logic [WORD_W-1:0] rs2_rdata,
    input  logic [WORD_W-1:0] mem_addr,
    input  logic [LANE_W-1:0] mem_rdata,
    input  logic [LANE_W-1:0] mem_wdata,
    input  logic [MASK_W-1:0] mem_rmask,
    input  logic [MASK_W-1:0] mem_wmask,
    output logic [HDR_W-1:0]  hdr,
    output logic [INTX_W-1:0] intx,
    output logic [MEMX_W-1:0] memx
);
    // header word offsets
    localparam int H_SIZE  = 64;
    localparam int H_META  = 128;
    localparam int H_PC    = 320;
    localparam int H_AVAIL = 448;
    // metadata byte fields, relative to H_META
    localparam int M_INSN  = 64;
    localparam int M_TRAP  = 128;

    logic [WORD_W-1:0] byte_count;

    always_comb begin
        byte_count = WORD_W'(HDR_W / 8);
        if (int_on) byte_count = byte_count + WORD_W'(INTX_W / 8);
        if (mem_on) byte_count = byte_count + WORD_W'(MEMX_W / 8);
    end

    always_comb begin
        hdr = '0;
        hdr[0 +: WORD_W]                       = HDR_MAGIC;
        hdr[H_SIZE +: WORD_W]                  = byte_count;
        hdr[H_META +: WORD_W]                  = order;
        hdr[H_META + M_INSN +: WORD_W]         = insn;
        hdr[H_META + M_TRAP +: 6*BYTE_W]       = {META_VALID_BYTE, ixl, mode, intr, halt, trap};
        hdr[H_PC +: 2*WORD_W]                  = {pc_wdata, pc_rdata};
        hdr[H_AVAIL]                           = int_on;
        hdr[H_AVAIL + 1]                       = mem_on;
    end

    always_comb begin
        intx = '0;
        intx[0 +: WORD_W]          = INT_MAGIC;
        intx[64 +: 3*WORD_W]       = {rs2_rdata, rs1_rdata, rd_wdata};
        intx[256 +: 3*BYTE_W]      = {rs2_addr, rs1_addr, rd_addr};
    end

    always_comb begin
        memx = '0;
        memx[0 +: WORD_W]          = MEM_MAGIC;
        memx[64 +: LANE_W]         = mem_rdata;
        memx[320 +: LANE_W]        = mem_wdata;
        memx[576 +: 2*MASK_W]      = {mem_wmask, mem_rmask};
        memx[640 +: WORD_W]        = mem_addr;
    end
endmodule

// File: rtl/rtrace_pack_legacy.sv
module rtrace_pack_legacy
    import rtrace_pkg::*;
(
    input  logic              cap_sel,
    input  logic [WORD_W-1:0] order,
    input  logic [WORD_W-1:0] insn,
    input  logic [BYTE_W-1:0] trap,
    input  logic [BYTE_W-1:0] halt,
    input  logic [BYTE_W-1:0] intr,
    input  logic [WORD_W-1:0] pc_rdata,
    input  logic [WORD_W-1:0] pc_wdata,
    input  logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rs1_addr,
    input  logic [BYTE_W-1:0] rs2_addr,
    input  logic [WORD_W-1:0] rd_wdata,
    input  logic [WORD_W-1:0] rs1_rdata,
    input  logic [WORD_W-1:0] rs2_rdata,
    input  logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata_lo,
    input  logic [WORD_W-1:0] mem_wdata_lo,
    input  logic [BYTE_W-1:0] mem_rmask_lo,
    input  logic [BYTE_W-1:0] mem_wmask_lo,
    output logic [LEG_W-1:0]  leg
);
    localparam int L_TAIL = 640;
    localparam int L_HALT = 688;

    always_comb begin
        leg = '0;
        if (cap_sel) begin
            leg[L_HALT +: BYTE_W] = CAP_HALT_BYTE;
        end else begin
            leg[0 +: 10*WORD_W] = {mem_wdata_lo, mem_rdata_lo, mem_addr, rd_wdata,
                                   rs2_rdata, rs1_rdata, insn, pc_wdata, pc_rdata, order};
            leg[L_TAIL +: 8*BYTE_W] = {intr, halt, trap, rd_addr, rs2_addr, rs1_addr,
                                       mem_wmask_lo, mem_rmask_lo};
        end
    end
endmodule

// File: rtl/rtrace_serializer.sv
module rtrace_serializer
    import rtrace_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_mode,
    input  logic              cap_req,
    input  logic              ret_valid,
    output logic              ret_ready,
    input  logic [63:0]       rt_order,
    input  logic [63:0]       rt_insn,
    input  logic [7:0]        rt_trap,
    input  logic [7:0]        rt_halt,
    input  logic [7:0]        rt_intr,
    input  logic [7:0]        rt_mode,
    input  logic [7:0]        rt_ixl,
    input  logic [63:0]       rt_pc_rdata,
    input  logic [63:0]       rt_pc_wdata,
    input  logic              rt_int_present,
    input  logic [7:0]        rt_rd_addr,
    input  logic [7:0]        rt_rs1_addr,
    input  logic [7:0]        rt_rs2_addr,
    input  logic [63:0]       rt_rd_wdata,
    input  logic [63:0]       rt_rs1_rdata,
    input  logic [63:0]       rt_rs2_rdata,
    input  logic              rt_mem_present,
    input  logic [63:0]       rt_mem_addr,
    input  logic [255:0]      rt_mem_rdata,
    input  logic [255:0]      rt_mem_wdata,
    input  logic [31:0]       rt_mem_rmask,
    input  logic [31:0]       rt_mem_wmask,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_data,
    output logic              out_last
);
    tx_state_e          st_q, st_d;
    logic [IDX_W-1:0]   idx_q, idx_d, seg_last;
    logic               at_end, fire, take_rec, take_cap;
    logic               int_q, mem_q;
    logic [HDR_W-1:0]   hdr_q, hdr_w;
    logic [INTX_W-1:0]  intx_q, intx_w;
    logic [MEMX_W-1:0]  body_q, memx_w;
    logic [LEG_W-1:0]   leg_w;
    logic [BEAT_W-1:0]  hdr_beat, int_beat, body_beat;

    // register values masked by presence and by zero register addresses
    logic [BYTE_W-1:0]  rd_a, rs1_a, rs2_a;
    logic [WORD_W-1:0]  rd_v, rs1_v, rs2_v, maddr;
    logic [LANE_W-1:0]  mrd, mwd;
    logic [MASK_W-1:0]  mrm, mwm;

    always_comb begin
        rd_a  = rt_int_present ? rt_rd_addr  : '0;
        rs1_a = rt_int_present ? rt_rs1_addr : '0;
        rs2_a = rt_int_present ? rt_rs2_addr : '0;
        rd_v  = (rd_a  != '0) ? rt_rd_wdata  : '0;
        rs1_v = (rs1_a != '0) ? rt_rs1_rdata : '0;
        rs2_v = (rs2_a != '0) ? rt_rs2_rdata : '0;
        maddr = rt_mem_present ? rt_mem_addr  : '0;
        mrd   = rt_mem_present ? rt_mem_rdata : '0;
        mwd   = rt_mem_present ? rt_mem_wdata : '0;
        mrm   = rt_mem_present ? rt_mem_rmask : '0;
        mwm   = rt_mem_present ? rt_mem_wmask : '0;
    end

    rtrace_pack_v2 u_pack_v2 (
        .order     (rt_order),
        .insn      (rt_insn),
        .trap      (rt_trap),
        .halt      (rt_halt),
        .intr      (rt_intr),
        .mode      (rt_mode),
        .ixl       (rt_ixl),
        .pc_rdata  (rt_pc_rdata),
        .pc_wdata  (rt_pc_wdata),
        .int_on    (rt_int_present),
        .mem_on    (rt_mem_present),
        .rd_addr   (rd_a),
        .rs1_addr  (rs1_a),
        .rs2_addr  (rs2_a),
        .rd_wdata  (rd_v),
        .rs1_rdata (rs1_v),
        .rs2_rdata (rs2_v),
        .mem_addr  (maddr),
        .mem_rdata (mrd),
        .mem_wdata (mwd),
        .mem_rmask (mrm),
        .mem_wmask (mwm),
        .hdr       (hdr_w),
        .intx      (intx_w),
        .memx      (memx_w)
    );

    rtrace_pack_legacy u_pack_leg (
        .cap_sel      (cap_req),
        .order        (rt_order),
        .insn         (rt_insn),
        .trap         (rt_trap),
        .halt         (rt_halt),
        .intr         (rt_intr),
        .pc_rdata     (rt_pc_rdata),
        .pc_wdata     (rt_pc_wdata),
        .rd_addr      (rd_a),
        .rs1_addr     (rs1_a),
        .rs2_addr     (rs2_a),
        .rd_wdata     (rd_v),
        .rs1_rdata    (rs1_v),
        .rs2_rdata    (rs2_v),
        .mem_addr     (maddr),
        .mem_rdata_lo (mrd[WORD_W-1:0]),
        .mem_wdata_lo (mwd[WORD_W-1:0]),
        .mem_rmask_lo (mrm[BYTE_W-1:0]),
        .mem_wmask_lo (mwm[BYTE_W-1:0]),
        .leg          (leg_w)
    );

    rtrace_beat_sel #(.SRC_W(HDR_W), .BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_sel_hdr (
        .src (hdr_q), .idx (idx_q), .beat (hdr_beat)
    );
    rtrace_beat_sel #(.SRC_W(INTX_W), .BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_sel_int (
        .src (intx_q), .idx (idx_q), .beat (int_beat)
    );
    rtrace_beat_sel #(.SRC_W(MEMX_W), .BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_sel_body (
        .src (body_q), .idx (idx_q), .beat (body_beat)
    );

    // last beat index of the segment being sent
    always_comb begin
        unique case (st_q)
            TX_IDLE:   seg_last = '0;
            TX_HEAD:   seg_last = IDX_W'(HDR_BEATS - 1);
            TX_INTX:   seg_last = IDX_W'(INT_BEATS - 1);
            TX_MEMX:   seg_last = IDX_W'(MEM_BEATS - 1);
            TX_LEGACY: seg_last = IDX_W'(LEG_BEATS - 1);
            default:   seg_last = '0;
        endcase
    end

    assign at_end = (idx_q == seg_last);

    // outputs
    always_comb begin
        out_valid = (st_q != TX_IDLE);
        ret_ready = (st_q == TX_IDLE) && !cap_req;
        out_data  = '0;
        out_last  = 1'b0;
        unique case (st_q)
            TX_IDLE: ;
            TX_HEAD: begin
                out_data = hdr_beat;
                out_last = at_end && !int_q && !mem_q;
            end
            TX_INTX: begin
                out_data = int_beat;
                out_last = at_end && !mem_q;
            end
            TX_MEMX, TX_LEGACY: begin
                out_data = body_beat;
                out_last = at_end;
            end
            default: ;
        endcase
    end

    assign fire     = out_valid && out_ready;
    assign take_cap = cap_req && (st_q == TX_IDLE);
    assign take_rec = ret_valid && ret_ready;

    // next state
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        if (fire) idx_d = at_end ? '0 : idx_q + 1'b1;
        unique case (st_q)
            TX_IDLE: begin
                if (take_cap)      st_d = TX_LEGACY;
                else if (take_rec) st_d = legacy_mode ? TX_LEGACY : TX_HEAD;
            end
            TX_HEAD: if (fire && at_end) begin
                if (int_q)      st_d = TX_INTX;
                else if (mem_q) st_d = TX_MEMX;
                else            st_d = TX_IDLE;
            end
            TX_INTX: if (fire && at_end) st_d = mem_q ? TX_MEMX : TX_IDLE;
            TX_MEMX: if (fire && at_end) st_d = TX_IDLE;
            TX_LEGACY: if (fire && at_end) st_d = TX_IDLE;
            default: st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // packet capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            intx_q <= '0;
            body_q <= '0;
            int_q  <= 1'b0;
            mem_q  <= 1'b0;
        end else if (take_cap) begin
            body_q <= leg_w;
        end else if (take_rec) begin
            hdr_q  <= hdr_w;
            intx_q <= intx_w;
            body_q <= legacy_mode ? leg_w : memx_w;
            int_q  <= rt_int_present;
            mem_q  <= rt_mem_present;
        end
    end
endmodule

// File: rtl/rtrace_serializer_chk.sv
module rtrace_serializer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        legacy_mode,
    input logic        cap_req,
    input logic        ret_valid,
    input logic        ret_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_data,
    input logic        out_last
);
    logic [4:0] beats_seen;
    logic       fire;

    assign fire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                beats_seen <= '0;
        else if (fire && out_last) beats_seen <= '0;
        else if (fire)             beats_seen <= beats_seen + 1'b1;
    end

    AST_BUSY_BLOCKS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !ret_ready); // R1
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R2
    AST_HEADER_MAGIC: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && ret_ready && !legacy_mode |=> out_valid && out_data == 64'h3276_2d65_6361_7274); // R3
    AST_LAST_ENDS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        fire && out_last |=> !out_valid); // R7
    AST_PACKET_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        fire && out_last |-> (beats_seen inside {5'd7, 5'd10, 5'd12, 5'd18, 5'd23})); // R7
    AST_CAP_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req && !out_valid |=> out_valid && out_data == 64'h0); // R10
    AST_CAP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req |-> !ret_ready); // R11
endmodule

bind rtrace_serializer rtrace_serializer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .legacy_mode (legacy_mode),
    .cap_req     (cap_req),
    .ret_valid   (ret_valid),
    .ret_ready   (ret_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_last    (out_last)
);

// File: tb/sim_rtrace_serializer.sv
module sim_rtrace_serializer;
    logic         clk = 1'b0;
    logic         rst_n, legacy_mode, cap_req, ret_valid, ret_ready;
    logic [63:0]  rt_order, rt_insn, rt_pc_rdata, rt_pc_wdata;
    logic [7:0]   rt_trap, rt_halt, rt_intr, rt_mode, rt_ixl;
    logic         rt_int_present, rt_mem_present;
    logic [7:0]   rt_rd_addr, rt_rs1_addr, rt_rs2_addr;
    logic [63:0]  rt_rd_wdata, rt_rs1_rdata, rt_rs2_rdata, rt_mem_addr;
    logic [255:0] rt_mem_rdata, rt_mem_wdata;
    logic [31:0]  rt_mem_rmask, rt_mem_wmask;
    logic         out_valid, out_ready, out_last;
    logic [63:0]  out_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    logic [63:0] exp_beat [24];
    string       exp_tag  [24];
    int          exp_n;

    always #10 clk = ~clk;

    rtrace_serializer u0 (.*);

    // vector: [27:20] rs2 addr, [19:12] rs1 addr, [11:4] rd addr, [3] stall, [2] legacy, [1] mem, [0] int
    localparam logic [27:0] VEC [8] = '{
        {8'd7, 8'd6, 8'd5, 4'b0011},
        {8'd2, 8'd3, 8'd4, 4'b1000},
        {8'd9, 8'd0, 8'd0, 4'b0001},
        {8'd1, 8'd2, 8'd3, 4'b1010},
        {8'd4, 8'd0, 8'd3, 4'b0111},
        {8'd8, 8'd8, 8'd8, 4'b1110},
        {8'd0, 8'd5, 8'd6, 4'b0101},
        {8'd0, 8'd1, 8'd0, 4'b1011}
    };

    function automatic logic [63:0] pv(int k, int f);
        return {8'(f), 8'hA5, 16'(k), 16'h5A00 | 16'(f), 16'(k * 3)};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive_fields(int k, logic [27:0] e);
        rt_int_present = e[0];
        rt_mem_present = e[1];
        legacy_mode    = e[2];
        rt_rd_addr     = e[11:4];
        rt_rs1_addr    = e[19:12];
        rt_rs2_addr    = e[27:20];
        rt_order       = pv(k, 1);
        rt_insn        = pv(k, 2) & 64'hFFFF_FFFF;
        rt_trap        = 8'(k + 1);
        rt_halt        = 8'(k + 2);
        rt_intr        = 8'(k + 3);
        rt_mode        = k[0] ? 8'd3 : 8'd1;
        rt_ixl         = 8'd2;
        rt_pc_rdata    = pv(k, 3);
        rt_pc_wdata    = pv(k, 4);
        rt_rd_wdata    = pv(k, 5);
        rt_rs1_rdata   = pv(k, 6);
        rt_rs2_rdata   = pv(k, 7);
        rt_mem_rdata   = {pv(k, 11), pv(k, 10), pv(k, 9), pv(k, 8)};
        rt_mem_wdata   = {pv(k, 15), pv(k, 14), pv(k, 13), pv(k, 12)};
        rt_mem_rmask   = 32'hC3C3_0000 | 32'(k);
        rt_mem_wmask   = 32'h3C3C_0000 | 32'(k + 16);
        rt_mem_addr    = pv(k, 16);
    endtask

    task automatic build_exp(int k, logic [27:0] e, bit cap);
        logic        ip, mp;
        logic [7:0]  rda, r1a, r2a, rm, wm;
        logic [63:0] rdw, r1d, r2d, ma;
        int          n;
        ip  = e[0];
        mp  = e[1];
        rda = ip ? e[11:4]  : 8'h0;
        r1a = ip ? e[19:12] : 8'h0;
        r2a = ip ? e[27:20] : 8'h0;
        rdw = (rda != 0) ? pv(k, 5) : 64'h0;
        r1d = (r1a != 0) ? pv(k, 6) : 64'h0;
        r2d = (r2a != 0) ? pv(k, 7) : 64'h0;
        ma  = mp ? pv(k, 16) : 64'h0;
        rm  = mp ? 8'(k) : 8'h0;
        wm  = mp ? 8'(k + 16) : 8'h0;
        n = 0;
        if (cap) begin
            for (int i = 0; i < 11; i++) begin exp_beat[i] = 64'h0; exp_tag[i] = "R10"; end
            exp_beat[10] = 64'h0003_0000_0000_0000;
            n = 11;
        end else if (e[2]) begin
            exp_beat[0]  = pv(k, 1);
            exp_beat[1]  = pv(k, 3);
            exp_beat[2]  = pv(k, 4);
            exp_beat[3]  = pv(k, 2) & 64'hFFFF_FFFF;
            exp_beat[4]  = r1d;
            exp_beat[5]  = r2d;
            exp_beat[6]  = rdw;
            exp_beat[7]  = ma;
            exp_beat[8]  = mp ? pv(k, 8) : 64'h0;
            exp_beat[9]  = mp ? pv(k, 12) : 64'h0;
            exp_beat[10] = {8'(k + 3), 8'(k + 2), 8'(k + 1), rda, r2a, r1a, wm, rm};
            for (int i = 0; i < 11; i++) exp_tag[i] = (i < 4) ? "R8" : "R9";
            n = 11;
        end else begin
            exp_beat[0] = 64'h3276_2d65_6361_7274;
            exp_beat[1] = 64'(64 + (ip ? 40 : 0) + (mp ? 88 : 0));
            exp_beat[2] = pv(k, 1);
            exp_beat[3] = pv(k, 2) & 64'hFFFF_FFFF;
            exp_beat[4] = {16'h0, 8'h01, 8'd2, (k[0] ? 8'd3 : 8'd1), 8'(k + 3), 8'(k + 2), 8'(k + 1)};
            exp_beat[5] = pv(k, 3);
            exp_beat[6] = pv(k, 4);
            exp_beat[7] = {62'h0, mp, ip};
            for (int i = 0; i < 8; i++) exp_tag[i] = "R3";
            n = 8;
            if (ip) begin
                exp_beat[n]   = 64'h6174_6164_2d74_6e69; exp_tag[n]   = "R4";
                exp_beat[n+1] = rdw;                     exp_tag[n+1] = "R5";
                exp_beat[n+2] = r1d;                     exp_tag[n+2] = "R5";
                exp_beat[n+3] = r2d;                     exp_tag[n+3] = "R5";
                exp_beat[n+4] = {40'h0, r2a, r1a, rda};  exp_tag[n+4] = "R4";
                n += 5;
            end
            if (mp) begin
                exp_beat[n] = 64'h6174_6164_2d6d_656d;
                for (int i = 0; i < 4; i++) exp_beat[n+1+i] = pv(k, 8 + i);
                for (int i = 0; i < 4; i++) exp_beat[n+5+i] = pv(k, 12 + i);
                exp_beat[n+9]  = {32'h3C3C_0000 | 32'(k + 16), 32'hC3C3_0000 | 32'(k)};
                exp_beat[n+10] = pv(k, 16);
                for (int i = 0; i < 11; i++) exp_tag[n+i] = "R6";
                n += 11;
            end
        end
        exp_n = n;
    endtask

    // starts and ends at a falling edge
    task automatic run_pkt(int k, logic [27:0] e, bit cap, bit poke_cap);
        logic [63:0] held;
        build_exp(k, e, cap);
        drive_fields(k, e);
        ret_valid = 1'b1;
        cap_req   = cap;
        out_ready = 1'b0;
        #1;
        chk(cap ? "R11 ret_ready with cap_req" : "R1 ret_ready idle", 64'(ret_ready), 64'(!cap));
        @(negedge clk);
        ret_valid   = 1'b0;
        cap_req     = 1'b0;
        legacy_mode = ~legacy_mode;       // R8: mode no longer looked at
        rt_order    = ~rt_order;          // record inputs no longer looked at
        rt_mem_rdata = ~rt_mem_rdata;
        for (int i = 0; i < exp_n; i++) begin
            if (e[3] && (i % 3 == 1)) begin
                out_ready = 1'b0;
                held = out_data;
                @(negedge clk);
                chk("R2 hold while stalled", out_data, held);
            end
            if (poke_cap && i == 2) cap_req = 1'b1;
            out_ready = 1'b1;
            #1;
            chk({"R7 valid ", exp_tag[i]}, 64'(out_valid), 64'd1);
            chk(exp_tag[i], out_data, exp_beat[i]);
            chk("R7 last marker", 64'(out_last), 64'(i == exp_n - 1));
            if (i == 0) chk("R1 ready low while busy", 64'(ret_ready), 64'd0);
            @(negedge clk);
            cap_req = 1'b0;
        end
        out_ready = 1'b0;
        #1;
        chk(poke_cap ? "R11 no packet from busy cap_req" : "R7 idle after last",
            64'(out_valid), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; legacy_mode = 1'b0; cap_req = 1'b0; ret_valid = 1'b0; out_ready = 1'b0;
        drive_fields(0, 28'h0);
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset out_valid", 64'(out_valid), 64'd0);
        chk("R1 reset ret_ready", 64'(ret_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < 8; v++) run_pkt(v + 1, VEC[v], 1'b0, v == 3);
        run_pkt(20, VEC[0], 1'b1, 1'b0);
        run_pkt(21, VEC[4], 1'b0, 1'b0);
        run_pkt(22, VEC[7], 1'b0, 1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule